// File: doc/BRIEF.md
# Race-Free Four-State Controller with Transit States

The block is a clocked model of a four-state controller driven by a two-bit input `w` (written w2w1) and producing a two-bit Moore output `z` (written z2z1). The four working states, named A, B, C and D, are placed on the corners of a three-bit cube. Every register update changes at most one state bit. A move between two working states whose codes differ in two bits therefore passes through one of three unstable transit codes, and the transit code lasts for a single clock. The present state code is also driven out on a port so that its single-bit stepping can be observed.

Working-state codes: A=000, B=001, D=010, C=100. Transit codes: T_BD=011 (between B and D), T_BC=101 (between B and C), T_CD=110 (between C and D). Code 111 is illegal. Transitions by input w2w1: A holds on 00 and 01, goes to C on 10 and to B on 11. B goes to A on 00, holds on 01 and 11, and goes to D on 10. C holds on 00 and 10, goes to B on 01 and to D on 11. D goes to C on 00 and to A on 01, and holds on 10 and 11.

While the controller is in a transit code, `z` already shows the code of the state it is heading for. This keeps any output code of a third state off `z` while the move is in progress. The reset is synchronous and active high.

Top module: `race_free_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes A (`state_code`=000) and `z`=00.
- R2: From A: inputs 00 and 01 hold A, 10 moves to C (100) and 11 moves to B (001), each in one clock.
- R3: From B: 00 moves to A, 01 and 11 hold B, and 10 enters T_BD (011) on the first clock and reaches D (010) on the second clock if the input is held.
- R4: From C: 00 and 10 hold C, 01 enters T_BC (101) and then reaches B, and 11 enters T_CD (110) and then reaches D, each with the input held.
- R5: From D: 10 and 11 hold D, 01 moves to A in one clock, and 00 enters T_CD (110) and then reaches C if the input is held.
- R6: Two consecutive state codes outside reset never differ in more than one bit. Moves into and out of the illegal code are excluded.
- R7: A transit code never lasts more than one clock. With the input held, it moves to its destination: T_BD on 10 to D, T_BC on 01 to B, T_CD on 11 to D and on 00 to C.
- R8: If the input changes during a transit, the next state is fixed by these rules. T_BD goes to D only on 10 and otherwise returns to B. T_BC goes to B only on 01 and otherwise goes to C. T_CD goes to D when w2=1 and otherwise to C.
- R9: In the working states, `z` is A=00, B=01, C=10 and D=11.
- R10: In the transit codes, `z` is 11 for T_BD and 01 for T_BC. For T_CD, `z` is 11 when w2=1 and 10 when w2=0.
- R11: The illegal code 111 shows `z`=00 and is replaced by A (000) at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| w | input | 2 | Controller input w2w1 |
| z | output | 2 | Controller output z2z1 |
| state_code | output | 3 | Present three-bit state code |

## Verification
The illegal code 111 cannot be reached from the ports, so R11 is checked by placing the code directly into the state register. The bench forces the code for a moment in the half cycle after a transit and then releases it, so that the register holds 111 until the next edge. The second hard case is a change of input while the controller is inside a transit code. To reach it, the bench enters each transit code from every origin state and then applies all four inputs on the following clock.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
    localparam int STATE_W = 3;
    localparam int IN_W    = 2;
    localparam int OUT_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_A    = 3'b000,
        ST_B    = 3'b001,
        ST_D    = 3'b010,
        ST_T_BD = 3'b011,
        ST_C    = 3'b100,
        ST_T_BC = 3'b101,
        ST_T_CD = 3'b110,
        ST_BAD  = 3'b111
    } state_t;

    localparam logic [OUT_W-1:0] Z_A = 2'b00;
    localparam logic [OUT_W-1:0] Z_B = 2'b01;
    localparam logic [OUT_W-1:0] Z_C = 2'b10;
    localparam logic [OUT_W-1:0] Z_D = 2'b11;
endpackage

// File: rtl/rfc_next.sv
module rfc_next
    import rfc_pkg::*;
(
    input  state_t            cur,
    input  logic [IN_W-1:0]   w,
    output state_t            nxt
);
    always_comb begin
        nxt = ST_A;
        unique case (cur)
            ST_A: begin
                unique case (w)
                    2'b10:   nxt = ST_C;
                    2'b11:   nxt = ST_B;
                    default: nxt = ST_A;
                endcase
            end
            ST_B: begin
                unique case (w)
                    2'b00:   nxt = ST_A;
                    2'b10:   nxt = ST_T_BD;
                    default: nxt = ST_B;
                endcase
            end
            ST_C: begin
                unique case (w)
                    2'b01:   nxt = ST_T_BC;
                    2'b11:   nxt = ST_T_CD;
                    default: nxt = ST_C;
                endcase
            end
            ST_D: begin
                unique case (w)
                    2'b00:   nxt = ST_T_CD;
                    2'b01:   nxt = ST_A;
                    default: nxt = ST_D;
                endcase
            end
            ST_T_BD: nxt = (w == 2'b10) ? ST_D : ST_B;
            ST_T_BC: nxt = (w == 2'b01) ? ST_B : ST_C;
            ST_T_CD: nxt = w[1] ? ST_D : ST_C;
            ST_BAD:  nxt = ST_A;
        endcase
    end
endmodule

// File: rtl/rfc_out.sv
module rfc_out
    import rfc_pkg::*;
(
    input  state_t            cur,
    input  logic [IN_W-1:0]   w,
    output logic [OUT_W-1:0]  z
);
    always_comb begin
        z = Z_A;
        unique case (cur)
            ST_A:    z = Z_A;
            ST_B:    z = Z_B;
            ST_C:    z = Z_C;
            ST_D:    z = Z_D;
            ST_T_BD: z = Z_D;
            ST_T_BC: z = Z_B;
            ST_T_CD: z = w[1] ? Z_D : Z_C;
            ST_BAD:  z = Z_A;
        endcase
    end
endmodule

// File: rtl/race_free_ctl.sv
module race_free_ctl
    import rfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        w,
    output logic [1:0]        z,
    output logic [2:0]        state_code
);
    state_t state_q;
    state_t state_d;

    rfc_next u_next (
        .cur (state_q),
        .w   (w),
        .nxt (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_A;
        else     state_q <= state_d;
    end

    rfc_out u_out (
        .cur (state_q),
        .w   (w),
        .z   (z)
    );

    assign state_code = state_q;
endmodule

// File: rtl/rfc_chk.sv
module rfc_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] w,
    input logic [1:0] z,
    input logic [2:0] code
);
    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(code) != 3'b111) && (code != 3'b111)) |-> ($countones(code ^ $past(code)) <= 1));

    // R7
    transit_once_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(code) == 2) |=> ($countones(code) != 2));

    // R11
    illegal_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (code == 3'b111) |=> (code == 3'b000));

    // R9
    home_out_chk: assert property (@(posedge clk) disable iff (rst)
        (code == 3'b000) |-> (z == 2'b00));

    // R9
    far_out_chk: assert property (@(posedge clk) disable iff (rst)
        (code == 3'b010) |-> (z == 2'b11));

    // R10
    cd_out_chk: assert property (@(posedge clk) disable iff (rst)
        ((code == 3'b110) && w[1]) |-> (z == 2'b11));
endmodule

bind race_free_ctl rfc_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .w    (w),
    .z    (z),
    .code (state_code)
);

// File: tb/sim_race_free_ctl.sv
`timescale 1ns/1ps
module sim_race_free_ctl;
    import rfc_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] w   = 2'b00;
    logic [1:0] z;
    logic [2:0] state_code;

    int total = 0;
    int bad   = 0;
    logic [2:0] exp_code = 3'b000;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    race_free_ctl u0 (
        .clk(clk), .rst(rst), .w(w), .z(z), .state_code(state_code)
    );

    // Destination of a working state for each input (R2..R5)
    function automatic logic [2:0] dest_m(input logic [2:0] s, input logic [1:0] wv);
        logic [2:0] d;
        d = s;
        case (s)
            3'b000: d = (wv == 2'b10) ? 3'b100 : (wv == 2'b11) ? 3'b001 : 3'b000;
            3'b001: d = (wv == 2'b00) ? 3'b000 : (wv == 2'b10) ? 3'b010 : 3'b001;
            3'b100: d = (wv == 2'b01) ? 3'b001 : (wv == 2'b11) ? 3'b010 : 3'b100;
            3'b010: d = (wv == 2'b00) ? 3'b100 : (wv == 2'b01) ? 3'b000 : 3'b010;
            default: d = s;
        endcase
        return d;
    endfunction

    function automatic logic [2:0] nxt_m(input logic [2:0] s, input logic [1:0] wv);
        logic [2:0] d;
        case (s)
            3'b011: return (wv == 2'b10) ? 3'b010 : 3'b001;
            3'b101: return (wv == 2'b01) ? 3'b001 : 3'b100;
            3'b110: return wv[1] ? 3'b010 : 3'b100;
            3'b111: return 3'b000;
            default: begin
                d = dest_m(s, wv);
                // a two-bit move goes to the transit code lying between both ends
                if ($countones(s ^ d) > 1) return s | d;
                return d;
            end
        endcase
    endfunction

    function automatic logic [1:0] z_m(input logic [2:0] s, input logic [1:0] wv);
        case (s)
            3'b000: return 2'b00;
            3'b001: return 2'b01;
            3'b100: return 2'b10;
            3'b010: return 2'b11;
            3'b011: return 2'b11;
            3'b101: return 2'b01;
            3'b110: return wv[1] ? 2'b11 : 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [2:0] gc, input logic [2:0] ec,
                         input logic [1:0] gz, input logic [1:0] ez);
        total++;
        if (gc !== ec || gz !== ez) begin
            bad++;
            $display("FAIL %s: code=%b z=%b expected code=%b z=%b", tag, gc, gz, ec, ez);
        end
    endtask

    task automatic step(input logic [1:0] wv, input string tag);
        logic [2:0] prev;
        @(negedge clk);
        w = wv;
        @(posedge clk);
        #1;
        prev = exp_code;
        exp_code = nxt_m(exp_code, wv);
        check(tag, state_code, exp_code, z, z_m(exp_code, wv));
        if (prev != 3'b111) begin
            total++;
            if ($countones(prev ^ state_code) > 1) begin
                bad++;
                $display("FAIL R6: step %b -> %b expected at most one bit change", prev, state_code);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        w = 2'b00;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset", state_code, 3'b000, z, 2'b00);
        @(negedge clk);
        rst = 1'b0;
        exp_code = 3'b000;
    endtask

    task automatic goto_state(input logic [2:0] s);
        do_reset();
        case (s)
            3'b001: step(2'b11, "R2 setup");
            3'b100: step(2'b10, "R2 setup");
            3'b010: begin
                step(2'b11, "R2 setup");
                step(2'b10, "R3 setup");
                step(2'b10, "R7 setup");
            end
            default: ;
        endcase
    endtask

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'b000: return "R2 from A";
            3'b001: return "R3 from B";
            3'b100: return "R4 from C";
            default: return "R5 from D";
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] homes [4];
        logic [2:0] origin [4];
        logic [1:0] entry [4];
        logic [7:0] lfsr;
        homes[0] = 3'b000; homes[1] = 3'b001; homes[2] = 3'b100; homes[3] = 3'b010;
        origin[0] = 3'b001; entry[0] = 2'b10;
        origin[1] = 3'b100; entry[1] = 2'b01;
        origin[2] = 3'b100; entry[2] = 2'b11;
        origin[3] = 3'b010; entry[3] = 2'b00;

        do_reset();

        // R2..R5, R7, R9, R10: every working state under every held input
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 4; k++) begin
                goto_state(homes[s]);
                step(k[1:0], tag_of(homes[s]));
                step(k[1:0], "R7 held input");
            end
        end

        // R8, R10: input changed while inside each transit code
        for (int t = 0; t < 4; t++) begin
            for (int k = 0; k < 4; k++) begin
                goto_state(origin[t]);
                step(entry[t], "R10 transit entry");
                step(k[1:0], "R8 changed input");
            end
        end

        // pseudo-random sweep, R6 and R9 on every step
        do_reset();
        lfsr = 8'hA5;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[1:0], "R9 sweep");
        end

        // R11: illegal code placed into the register during a transit
        goto_state(3'b001);
        step(2'b10, "R3 transit");
        @(negedge clk);
        force u0.state_q = ST_BAD;
        #1;
        release u0.state_q;
        #1;
        check("R11 illegal shown", state_code, 3'b111, z, 2'b00);
        @(posedge clk);
        #1;
        check("R11 recovery", state_code, 3'b000, z, 2'b00);
        exp_code = 3'b000;
        step(2'b11, "R2 after recovery");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule